// File: doc/BRIEF.md
# Video Stream Resolution Detector and Frame Capture

This block samples a parallel pixel stream on every rising edge of the pixel clock. The stream carries a vertical sync, a data-enable, a per-pixel valid flag and three 8-bit colour channels. The block learns the active width and height from the stream itself, with no configuration. It also counts frames, pulses at every line end and emits a word-wide write port for an external frame memory.

Width is the number of valid pixels seen while data-enable is high, and is latched when data-enable drops. Height is the number of completed lines at the first frame boundary. Capture begins only at that boundary, so the first partial frame is never stored. Pixels arriving with the valid flag low stand for underflow. They are neither counted nor written.

Top module: `vid_res_capture`

## Requirements
- R1: A synchronous active-high reset clears width, height, frame count, line-done and the write strobe, and disables capture.
- R2: The horizontal position advances only on cycles where data-enable and pixel-valid are both high. On the first data-enable-low cycle with a nonzero position, the width output takes that position, and it is overwritten at every such line end. A data-enable burst with no valid pixel ends no line.
- R3: The line-done output is a one-cycle pulse in the cycle after the first data-enable-low sample that follows a nonzero position. It never pulses when the position is zero.
- R4: Vsync sampled high while the line count is nonzero marks a frame boundary. The frame counter (16 bits) increments by one and the line count returns to 0. Vsync sampled with a zero line count has no effect.
- R5: At the first frame boundary after reset, the height output takes the current line count. It keeps that value at all later boundaries.
- R6: No memory write occurs before the first frame boundary.
- R7: With capture enabled, the write strobe is high for exactly the cycle after a sample with data-enable and pixel-valid both high, and low after any other sample.
- R8: The write data word holds red in bits 7:0, green in bits 15:8 and blue in bits 23:16, with bits 31:24 zero.
- R9: The write address is a word index equal to line count × learned width + horizontal position. Lines are counted from 0 after each frame boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| vsync | input | 1 | Vertical sync |
| de | input | 1 | Data enable (active region) |
| pix_valid | input | 1 | Pixel valid; low marks an underflow cycle |
| red | input | 8 | Red channel |
| grn | input | 8 | Green channel |
| blu | input | 8 | Blue channel |
| width_o | output | 11 | Learned active width |
| height_o | output | 11 | Learned active height |
| frame_cnt_o | output | 16 | Frame boundary count |
| line_done_o | output | 1 | One-cycle pulse per completed line |
| wr_en_o | output | 1 | Frame memory write strobe |
| wr_addr_o | output | 22 | Frame memory word address |
| wr_data_o | output | 32 | Frame memory write word |

## Verification
Several rules hold on every cycle and are checked by the assertions. A strobe must follow a sample with both data-enable and valid high, and no strobe may come while height is still zero. The pad byte must be zero, the frame counter may only step by one, and the height may not move once learned. Line-done must follow a data-enable-low sample and never repeat on the next cycle. Only the bench scenarios can show the learned width and height values, exact addresses and pixel data, the total write count per frame, the no-effect cases (repeated vsync, an all-underflow burst) and the re-learning of a shorter width.

// File: rtl/vrc_pkg.sv
package vrc_pkg;

    localparam int COLOR_W = 8;
    localparam int WORD_W  = 4 * COLOR_W;

    typedef struct packed {
        logic [COLOR_W-1:0] blu;
        logic [COLOR_W-1:0] grn;
        logic [COLOR_W-1:0] red;
    } rgb_t;

    // Byte lanes: red low, green next, blue next, top byte padded with zero.
    function automatic logic [WORD_W-1:0] pack_word(input rgb_t p);
        return {{COLOR_W{1'b0}}, p.blu, p.grn, p.red};
    endfunction

endpackage

// File: rtl/vrc_hcount.sv
module vrc_hcount #(
    parameter int W_BITS = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              de,
    input  logic              pix_valid,
    output logic [W_BITS-1:0] xpos,
    output logic [W_BITS-1:0] width,
    output logic              line_end,
    output logic              line_done
);

    assign line_end = !de && (xpos != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            xpos      <= '0;
            width     <= '0;
            line_done <= 1'b0;
        end else begin
            line_done <= line_end;
            if (de) begin
                if (pix_valid) begin
                    xpos <= xpos + W_BITS'(1);
                end
            end else if (line_end) begin
                width <= xpos;
                xpos  <= '0;
            end
        end
    end

endmodule

// File: rtl/vrc_vcount.sv
module vrc_vcount #(
    parameter int H_BITS = 11,
    parameter int F_BITS = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              vsync,
    input  logic              line_end,
    output logic [H_BITS-1:0] line_eff,
    output logic [H_BITS-1:0] height,
    output logic [F_BITS-1:0] frame_cnt,
    output logic              cap_on
);

    logic [H_BITS-1:0] line_q;
    logic              cap_q;
    logic              frame_start;

    assign frame_start = vsync && (line_q != '0);
    // Line index valid for this cycle, after any frame boundary.
    assign line_eff    = frame_start ? '0 : line_q;
    assign cap_on      = cap_q || frame_start;

    always_ff @(posedge clk) begin
        if (rst) begin
            line_q    <= '0;
            height    <= '0;
            frame_cnt <= '0;
            cap_q     <= 1'b0;
        end else begin
            line_q <= line_end ? line_eff + H_BITS'(1) : line_eff;
            if (frame_start) begin
                frame_cnt <= frame_cnt + F_BITS'(1);
                cap_q     <= 1'b1;
                if (height == '0) begin
                    height <= line_q;
                end
            end
        end
    end

endmodule

// File: rtl/vrc_wport.sv
module vrc_wport
    import vrc_pkg::*;
#(
    parameter int W_BITS = 11,
    parameter int H_BITS = 11,
    parameter int ADDR_W = W_BITS + H_BITS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_req,
    input  logic [H_BITS-1:0] line_idx,
    input  logic [W_BITS-1:0] width,
    input  logic [W_BITS-1:0] xpos,
    input  rgb_t              pix,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [WORD_W-1:0] wr_data
);

    logic [ADDR_W-1:0] row_base;
    logic [ADDR_W-1:0] addr_nxt;

    assign row_base = ADDR_W'(line_idx) * ADDR_W'(width);
    assign addr_nxt = row_base + ADDR_W'(xpos);

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_en   <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
        end else begin
            wr_en <= wr_req;
            if (wr_req) begin
                wr_addr <= addr_nxt;
                wr_data <= pack_word(pix);
            end
        end
    end

endmodule

// File: rtl/vid_res_capture.sv
module vid_res_capture
    import vrc_pkg::*;
#(
    parameter int W_BITS = 11,
    parameter int H_BITS = 11,
    parameter int F_BITS = 16,
    localparam int ADDR_W = W_BITS + H_BITS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              vsync,
    input  logic              de,
    input  logic              pix_valid,
    input  logic [7:0]        red,
    input  logic [7:0]        grn,
    input  logic [7:0]        blu,
    output logic [W_BITS-1:0] width_o,
    output logic [H_BITS-1:0] height_o,
    output logic [F_BITS-1:0] frame_cnt_o,
    output logic              line_done_o,
    output logic              wr_en_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [31:0]       wr_data_o
);

    logic [W_BITS-1:0] xpos;
    logic [H_BITS-1:0] line_eff;
    logic              line_end;
    logic              cap_on;
    logic              wr_req;
    rgb_t              pix;

    assign pix    = '{blu: blu, grn: grn, red: red};
    assign wr_req = de && pix_valid && cap_on;

    vrc_hcount #(.W_BITS(W_BITS)) i_hcount (
        .clk       (clk),
        .rst       (rst),
        .de        (de),
        .pix_valid (pix_valid),
        .xpos      (xpos),
        .width     (width_o),
        .line_end  (line_end),
        .line_done (line_done_o)
    );

    vrc_vcount #(.H_BITS(H_BITS), .F_BITS(F_BITS)) i_vcount (
        .clk       (clk),
        .rst       (rst),
        .vsync     (vsync),
        .line_end  (line_end),
        .line_eff  (line_eff),
        .height    (height_o),
        .frame_cnt (frame_cnt_o),
        .cap_on    (cap_on)
    );

    vrc_wport #(.W_BITS(W_BITS), .H_BITS(H_BITS), .ADDR_W(ADDR_W)) i_wport (
        .clk      (clk),
        .rst      (rst),
        .wr_req   (wr_req),
        .line_idx (line_eff),
        .width    (width_o),
        .xpos     (xpos),
        .pix      (pix),
        .wr_en    (wr_en_o),
        .wr_addr  (wr_addr_o),
        .wr_data  (wr_data_o)
    );

endmodule

// File: rtl/vrc_checker.sv
module vrc_checker #(
    parameter int H_BITS = 11,
    parameter int F_BITS = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              de,
    input logic              pix_valid,
    input logic [H_BITS-1:0] height_o,
    input logic [F_BITS-1:0] frame_cnt_o,
    input logic              line_done_o,
    input logic              wr_en_o,
    input logic [31:0]       wr_data_o
);

    AST_STROBE_AFTER_VALID: assert property (@(posedge clk) disable iff (rst)
        wr_en_o |-> $past(de && pix_valid)) else $error("strobe without valid pixel"); // R7

    AST_NO_WRITE_UNLEARNED: assert property (@(posedge clk) disable iff (rst)
        wr_en_o |-> (height_o != '0)) else $error("write before first frame"); // R6

    AST_HEIGHT_HELD: assert property (@(posedge clk) disable iff (rst)
        (height_o != '0) |=> $stable(height_o)) else $error("height changed"); // R5

    AST_FRAME_STEP: assert property (@(posedge clk) disable iff (rst)
        (!$stable(frame_cnt_o) && !$past(rst)) |-> (frame_cnt_o == $past(frame_cnt_o) + F_BITS'(1)))
        else $error("frame counter jump"); // R4

    AST_DONE_AFTER_DE_LOW: assert property (@(posedge clk) disable iff (rst)
        line_done_o |-> $past(!de)) else $error("line done without de low"); // R3

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        line_done_o |=> !line_done_o) else $error("line done longer than one cycle"); // R3

    AST_PAD_BYTE_ZERO: assert property (@(posedge clk) disable iff (rst)
        wr_en_o |-> (wr_data_o[31:24] == 8'h00)) else $error("pad byte nonzero"); // R8

endmodule

bind vid_res_capture vrc_checker #(.H_BITS(H_BITS), .F_BITS(F_BITS)) i_vrc_checker (
    .clk         (clk),
    .rst         (rst),
    .de          (de),
    .pix_valid   (pix_valid),
    .height_o    (height_o),
    .frame_cnt_o (frame_cnt_o),
    .line_done_o (line_done_o),
    .wr_en_o     (wr_en_o),
    .wr_data_o   (wr_data_o)
);

// File: tb/test_vid_res_capture.sv
module test_vid_res_capture;

    localparam int CLK_PERIOD = 10;
    localparam int N_LINES    = 4;

    // Each entry: [15:12] expected width, [11:0] valid mask over 12 de-high cycles.
    localparam logic [15:0] LINE_TAB [N_LINES] = '{
        16'h80FF,
        16'h8B6D,
        16'h8F0F,
        16'h86DB
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        vsync = 1'b0;
    logic        de = 1'b0;
    logic        pix_valid = 1'b0;
    logic [7:0]  red = '0;
    logic [7:0]  grn = '0;
    logic [7:0]  blu = '0;
    logic [10:0] width_o;
    logic [10:0] height_o;
    logic [15:0] frame_cnt_o;
    logic        line_done_o;
    logic        wr_en_o;
    logic [21:0] wr_addr_o;
    logic [31:0] wr_data_o;

    int n_checks = 0;
    int n_errors = 0;
    int wr_seen  = 0;
    bit cap_exp  = 1'b0;
    bit finished = 1'b0;
    int cur_w    = 8;

    always #(CLK_PERIOD/2) clk = ~clk;

    vid_res_capture i_vid_res_capture (
        .clk (clk), .rst (rst), .vsync (vsync), .de (de), .pix_valid (pix_valid),
        .red (red), .grn (grn), .blu (blu),
        .width_o (width_o), .height_o (height_o), .frame_cnt_o (frame_cnt_o),
        .line_done_o (line_done_o), .wr_en_o (wr_en_o),
        .wr_addr_o (wr_addr_o), .wr_data_o (wr_data_o)
    );

    task automatic check(input string req, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Drive one sample, let one edge pass, then inspect outputs away from the edge.
    task automatic step(input bit vs, input bit d, input bit v,
                        input logic [7:0] r, input logic [7:0] g, input logic [7:0] b,
                        input bit exp_ld);
        bit exp_wr;
        vsync = vs; de = d; pix_valid = v; red = r; grn = g; blu = b;
        @(posedge clk);
        @(negedge clk);
        exp_wr = d && v && cap_exp;
        check("R3 line_done", line_done_o, exp_ld);
        check(cap_exp ? "R7 strobe" : "R6 strobe before capture", wr_en_o, exp_wr);
        if (wr_en_o) wr_seen++;
        if (exp_wr && wr_en_o) begin
            check("R9 address", wr_addr_o, r * cur_w + g);
            check("R8 data", wr_data_o, {8'h00, b, g, r});
        end
    endtask

    task automatic drive_line(input logic [15:0] ent, input int row, input logic [7:0] tag);
        int x = 0;
        for (int i = 0; i < 12; i++) begin
            step(1'b0, 1'b1, ent[i], 8'(row), 8'(x), tag, 1'b0);
            if (ent[i]) x++;
        end
        step(1'b0, 1'b0, 1'b0, 8'h0, 8'h0, 8'h0, 1'b1);
        check("R2 width", width_o, ent[15:12]);
        for (int i = 0; i < 2; i++) step(1'b0, 1'b0, 1'b0, 8'h0, 8'h0, 8'h0, 1'b0);
    endtask

    task automatic run_frame(input logic [7:0] tag);
        for (int l = 0; l < N_LINES; l++) drive_line(LINE_TAB[l], l, tag);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        check("R1 width", width_o, 0);
        check("R1 height", height_o, 0);
        check("R1 frame", frame_cnt_o, 0);
        check("R1 line_done", line_done_o, 0);
        check("R1 strobe", wr_en_o, 0);
        rst = 1'b0;

        // Partial first frame: widths learned, nothing stored (R6)
        wr_seen = 0;
        run_frame(8'h11);
        check("R6 writes before boundary", wr_seen, 0);
        check("R5 height unknown", height_o, 0);
        check("R4 frame before vsync", frame_cnt_o, 0);

        // First boundary (R4, R5)
        step(1'b1, 1'b0, 1'b0, 8'h0, 8'h0, 8'h0, 1'b0);
        cap_exp = 1'b1;
        check("R5 height learned", height_o, N_LINES);
        check("R4 frame count", frame_cnt_o, 1);
        // Vsync held with line count zero: no further boundary (R4)
        step(1'b1, 1'b0, 1'b0, 8'h0, 8'h0, 8'h0, 1'b0);
        step(1'b1, 1'b0, 1'b0, 8'h0, 8'h0, 8'h0, 1'b0);
        check("R4 held vsync", frame_cnt_o, 1);

        // Captured frame: one write per valid pixel (R7)
        wr_seen = 0;
        run_frame(8'h22);
        check("R7 writes per frame", wr_seen, 32);
        step(1'b1, 1'b0, 1'b0, 8'h0, 8'h0, 8'h0, 1'b0);
        check("R4 second frame", frame_cnt_o, 2);
        check("R5 height kept", height_o, N_LINES);

        // Underflow-only burst: no line end, no write, width kept (R2)
        wr_seen = 0;
        for (int i = 0; i < 6; i++) step(1'b0, 1'b1, 1'b0, 8'h7, 8'h7, 8'h7, 1'b0);
        step(1'b0, 1'b0, 1'b0, 8'h0, 8'h0, 8'h0, 1'b0);
        check("R2 width after empty burst", width_o, 8);
        check("R7 no write on underflow", wr_seen, 0);
        // Next line must still be row 0 (R9)
        drive_line(LINE_TAB[0], 0, 8'h33);

        // Shorter line re-learns width (R2)
        drive_line(16'h501F, 1, 8'h33);
        check("R2 width shrinks", width_o, 5);
        step(1'b1, 1'b0, 1'b0, 8'h0, 8'h0, 8'h0, 1'b0);
        check("R4 third frame", frame_cnt_o, 3);
        check("R5 height not relearned", height_o, N_LINES);

        // Reset mid-stream (R1)
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check("R1 width after reset", width_o, 0);
        check("R1 height after reset", height_o, 0);
        check("R1 frame after reset", frame_cnt_o, 0);
        rst = 1'b0;

        finished = 1'b1;
        summary();
        $finish;
    end

endmodule